// File: doc/BRIEF.md
# Three Consecutive Ones Detector

This block watches a single-bit serial stream and takes one sample of it on every rising clock edge. When the sample now on the input would complete a run of three ones in a row, it raises a detect flag for that one cycle. A two-bit state register records how long the current run of ones is. Combinational logic turns the present state and the present input into the next state and into the detect flag. Because the flag comes from the input as well as the state, it is a Mealy output and does not wait for the next clock edge.

Detection does not overlap. After a hit the machine goes back to its idle state, so a fresh run of three ones is needed before the next hit. An unbroken stream of ones is therefore reported on every third bit, not on every bit after the second.

The machine has three named states. RUN_NONE (code 00) means no ones are pending. RUN_ONE (code 01) means one one is pending. RUN_TWO (code 10) means two ones are pending. Code 11 (RUN_BAD) is never entered in normal operation. The transitions are named as follows:
- ZERO_CLEAR: any state with input 0 goes to RUN_NONE.
- FIRST_ONE: RUN_NONE with input 1 goes to RUN_ONE.
- SECOND_ONE: RUN_ONE with input 1 goes to RUN_TWO.
- THIRD_HIT: RUN_TWO with input 1 raises detect and goes to RUN_NONE.
- BAD_RECOVER: RUN_BAD goes to RUN_NONE.
- RESET_CLEAR: reset from any state goes to RUN_NONE.

Top module: `triple_one_detector`

## Requirements
- R1: The state register is 2 bits wide. Code 00 means no ones pending, 01 means one one pending and 10 means two ones pending. After reset the state is 00, and code 11 is never reached from reset.
- R2: In any state, an input of 0 holds detect low in that cycle and makes the next state 00.
- R3: From 00, an input of 1 moves to 01. From 01, an input of 1 moves to 10. Detect stays low on both of these moves.
- R4: In state 10, an input of 1 drives detect high in that same cycle, and the next state is 00.
- R5: The reset `rst_i` is synchronous and active-high. It forces the state to 00 on the next rising edge, it overrides the next-state logic, and it holds detect low while it is asserted.
- R6: With the input held at 1 on every cycle from the release of reset, detect is high exactly on the 3rd, 6th, 9th and later multiples-of-three cycles, and low on every other cycle.
- R7: Detection is non-overlapping. After a hit, detect stays low until three further consecutive ones have been sampled.
- R8: Detect is combinational in the present state and present input. A change of `serial_i` within a cycle is reflected on `detect_o` in that same cycle, with no register delay.
- R9: The state changes only on the rising clock edge, and the input is sampled once per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state advances on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| serial_i | input | 1 | Serial data bit, sampled once per cycle |
| detect_o | output | 1 | High in the cycle where the current bit completes three ones |

## Verification
The bench targets the following corner cases:
- **Long unbroken runs of ones.** A design that detects with overlap would fire on the 4th and 5th ones. A design that resets to the wrong state would fire on the wrong phase.
- **A zero arriving in state RUN_TWO.** A design that forgets to clear there would fire one bit too early on the following ones.
- **Reset asserted in the middle of a run, with the input held at 1.** A design without reset priority would either report a hit during reset or carry a partial run across it.
- **A mid-cycle change of the input while in RUN_TWO.** This exposes a detect output that was registered by mistake, because such an output would lag by one cycle.

Random biased streams are compared cycle by cycle against a run-length reference model.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Width of the run-length state register.
    localparam int STATE_W = 2;

    // Number of consecutive ones that makes a hit.
    localparam int RUN_LEN = 3;

    typedef enum logic [STATE_W-1:0] {
        RUN_NONE = 2'b00,
        RUN_ONE  = 2'b01,
        RUN_TWO  = 2'b10,
        RUN_BAD  = 2'b11
    } run_e;

endpackage

// File: rtl/tod_state.sv
module tod_state
    import tod_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  run_e nxt_i,
    output run_e cur_o
);

    // RESET_CLEAR takes priority over the next-state logic.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_o <= RUN_NONE;
        end else begin
            cur_o <= nxt_i;
        end
    end

endmodule

// File: rtl/tod_next.sv
module tod_next
    import tod_pkg::*;
(
    input  run_e cur_i,
    input  logic bit_i,
    output run_e nxt_o
);

    always_comb begin
        nxt_o = RUN_NONE;
        unique case (cur_i)
            // FIRST_ONE when the bit is 1, otherwise ZERO_CLEAR.
            RUN_NONE: nxt_o = bit_i ? RUN_ONE : RUN_NONE;
            // SECOND_ONE when the bit is 1, otherwise ZERO_CLEAR.
            RUN_ONE:  nxt_o = bit_i ? RUN_TWO : RUN_NONE;
            // Both THIRD_HIT and ZERO_CLEAR return to idle.
            RUN_TWO:  nxt_o = RUN_NONE;
            // BAD_RECOVER.
            RUN_BAD:  nxt_o = RUN_NONE;
        endcase
    end

endmodule

// File: rtl/tod_out.sv
module tod_out
    import tod_pkg::*;
(
    input  run_e cur_i,
    input  logic bit_i,
    input  logic rst_i,
    output logic hit_o
);

    always_comb begin
        hit_o = 1'b0;
        unique case (cur_i)
            RUN_NONE: hit_o = 1'b0;
            RUN_ONE:  hit_o = 1'b0;
            RUN_TWO:  hit_o = bit_i & ~rst_i;
            RUN_BAD:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/triple_one_detector.sv
module triple_one_detector
    import tod_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic serial_i,
    output logic detect_o
);

    run_e state_q;
    run_e state_d;

    tod_state u_state (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .nxt_i (state_d),
        .cur_o (state_q)
    );

    tod_next u_next (
        .cur_i (state_q),
        .bit_i (serial_i),
        .nxt_o (state_d)
    );

    tod_out u_out (
        .cur_i (state_q),
        .bit_i (serial_i),
        .rst_i (rst_i),
        .hit_o (detect_o)
    );

endmodule

// File: rtl/triple_one_detector_chk.sv
module triple_one_detector_chk
    import tod_pkg::*;
(
    input logic clk_i,
    input logic rst_i,
    input logic serial_i,
    input logic detect_o,
    input run_e state_q
);

    a_r1_no_bad_code: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q != RUN_BAD);

    a_r2_zero_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        !serial_i |=> state_q == RUN_NONE);

    a_r2_zero_no_hit: assert property (@(posedge clk_i) disable iff (rst_i)
        !serial_i |-> !detect_o);

    a_r3_first_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == RUN_NONE && serial_i) |=> state_q == RUN_ONE);

    a_r3_second_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == RUN_ONE && serial_i) |=> state_q == RUN_TWO);

    a_r4_hit_source: assert property (@(posedge clk_i) disable iff (rst_i)
        detect_o |-> (state_q == RUN_TWO && serial_i));

    a_r4_hit_then_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        detect_o |=> state_q == RUN_NONE);

    a_r5_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> state_q == RUN_NONE);

    a_r5_reset_quiet: assert property (@(posedge clk_i)
        rst_i |-> !detect_o);

endmodule

bind triple_one_detector triple_one_detector_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .serial_i (serial_i),
    .detect_o (detect_o),
    .state_q  (state_q)
);

// File: tb/tb_triple_one_detector.sv
`timescale 1ns/1ps
module tb_triple_one_detector;

    localparam time CLK_PER = 20ns;

    typedef struct {
        bit    exp;
        string req;
    } item_t;

    logic clk_i = 1'b0;
    logic rst_i = 1'b1;
    logic serial_i = 1'b0;
    logic detect_o;

    int   n_tests = 0;
    int   n_fail = 0;
    int   run_cnt = 0;
    bit   done = 1'b0;
    item_t sb[$];

    triple_one_detector dut (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .serial_i (serial_i),
        .detect_o (detect_o)
    );

    always #(CLK_PER / 2) clk_i = ~clk_i;

    // Driver: applies one bit (and reset) per cycle and pushes the expected detect value.
    task automatic drive(input bit b, input bit r, input string req);
        item_t it;
        @(negedge clk_i);
        #1;
        serial_i = b;
        rst_i = r;
        it.req = req;
        if (r) begin
            it.exp = 1'b0;
            run_cnt = 0;
        end else begin
            it.exp = (run_cnt == 2) && b;
            if (!b || run_cnt == 2) run_cnt = 0;
            else run_cnt = run_cnt + 1;
        end
        sb.push_back(it);
    endtask

    // Monitor: pops and compares in the middle of the low phase of the clock.
    initial begin
        forever begin
            @(negedge clk_i);
            #5;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_tests++;
                if (detect_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: detect_o=%0b expected=%0b at %0t",
                             it.req, detect_o, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #(CLK_PER * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R5: reset held for several cycles with the input at 1; detect stays low.
        drive(1, 1, "R5");
        drive(1, 1, "R5");
        drive(1, 1, "R5");

        // R1: reset state is idle, so exactly three ones are needed for a hit.
        // R3: the first two ones give no hit; R4: the third one gives a hit.
        drive(1, 0, "R1");
        drive(1, 0, "R3");
        drive(1, 0, "R4");

        // R6 and R7: all ones, hits only on every third cycle.
        for (int i = 0; i < 12; i++) drive(1, 0, "R6");
        drive(0, 0, "R2");

        // R2: a zero in state two clears the run.
        drive(1, 0, "R3");
        drive(1, 0, "R3");
        drive(0, 0, "R2");
        drive(1, 0, "R2");
        drive(1, 0, "R2");
        drive(1, 0, "R4");

        // R7: 1111 then 0 gives only one hit.
        drive(1, 0, "R7");
        drive(1, 0, "R7");
        drive(1, 0, "R7");
        drive(1, 0, "R7");
        drive(0, 0, "R7");

        // R5: reset in the middle of a run overrides the pending ones.
        drive(1, 0, "R5");
        drive(1, 0, "R5");
        drive(1, 1, "R5");
        drive(1, 0, "R5");
        drive(1, 0, "R5");
        drive(1, 0, "R5");

        // R8: a mid-cycle input change is seen on detect in the same cycle.
        drive(0, 0, "R8");
        drive(1, 0, "R8");
        drive(1, 0, "R8");
        @(negedge clk_i);
        #1;
        serial_i = 1'b0;
        #2;
        n_tests++;
        if (detect_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: detect_o=%0b expected=0 (input 0, state two)", detect_o);
        end
        begin
            item_t it;
            serial_i = 1'b1;
            it.exp = 1'b1;
            it.req = "R8";
            run_cnt = 0;
            sb.push_back(it);
        end

        // R9 and R2/R3/R4: random ones-biased streams against the reference model.
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 4) != 0, 0, "R9");
        end

        drive(0, 0, "R2");
        repeat (3) @(negedge clk_i);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule